// File: doc/BRIEF.md
# Transmit jabber watchdog

This block watches the transmit-enable line of one network port and catches a transmission that runs on far longer than any legal frame. Once such a run is seen, the watchdog latches a jabber state. While latched it blocks the transmit output and forces carrier sense inactive. Whenever the host keeps trying to send, it raises a link-fail request. In half duplex it also raises a collision request during those attempts.

The latch releases only after transmit enable has stayed low for a long, unbroken quiet period. Both the trip length and the quiet length are parameters counted in clock cycles. The defaults match 20 ms and 500 ms at the 250 MHz clock, and a bench can shrink them. The block does not drive the line and does not detect real collisions. Its four request outputs are meant to be ORed into the port's own transmit, carrier and collision logic.

Top module: `jabber_watchdog`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `jabberActive`, `txDisable`, `crsKill`, `colReq` and `linkFailReq` are all 0, and the trip count starts from zero.
- R2: `jabberActive` goes to 1 after the clock edge that samples `txEn` high for the TRIP_CYCLES+1-th consecutive time. A run of exactly TRIP_CYCLES high samples does not trip.
- R3: `txDisable` and `crsKill` are 1 exactly when `jabberActive` is 1.
- R4: While jabber is latched, `linkFailReq` equals `txEn` in the same cycle, in either duplex mode.
- R5: `colReq` is 1 only when jabber is latched, `txEn` is 1 and `fullDuplex` is 0. With `fullDuplex` at 1 it stays 0.
- R6: A single low sample of `txEn` resets the trip count to zero, so each new high run is timed from its own start.
- R7: Jabber clears after the edge that samples `txEn` low for the UNJAB_CYCLES-th consecutive time. All outputs are 0 from then on until a new trip.
- R8: A high sample of `txEn` while jabber is latched restarts the quiet count from zero.
- R9: While jabber is not latched, all four request outputs stay 0 whatever `txEn` and `fullDuplex` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| txEn | input | 1 | Transmit enable from the host, active high |
| fullDuplex | input | 1 | 1 = full duplex, 0 = half duplex |
| jabberActive | output | 1 | Jabber latched |
| txDisable | output | 1 | Blocks the transmit output |
| crsKill | output | 1 | Forces carrier sense inactive |
| colReq | output | 1 | Collision request during attempts in half duplex |
| linkFailReq | output | 1 | Link-fail request during attempts |

## Verification
The assertions assume that `txEn` and `fullDuplex` are synchronous to `clk` and settle well before each rising edge. They also assume that `fullDuplex` holds the value meant for the cycle it is sampled in; it is never treated as a registered mode. The bench changes every input only on the falling edge and reads outputs one nanosecond after the rising edge. It overrides both durations with small values, so each boundary is reached exactly: one sample short of the limit, and the limit itself.

// File: rtl/jabwd_pkg.sv
package jabwd_pkg;

  typedef enum logic {
    ST_ARMED  = 1'b0,
    ST_JABBED = 1'b1
  } jabState_e;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic tripInc;
    logic tripClr;
    logic quietInc;
    logic quietClr;
  } jabStrobe_t;

endpackage

// File: rtl/jab_counters.sv
module jab_counters
  import jabwd_pkg::*;
#(
  parameter int unsigned TRIP_CYCLES  = 5_000_000,
  parameter int unsigned UNJAB_CYCLES = 125_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  jabStrobe_t strobe,
  output logic       tripHit,
  output logic       quietHit,
  output logic       tripZero,
  output logic       quietZero
);
  localparam int unsigned TW = $clog2(TRIP_CYCLES + 1);
  localparam int unsigned QW = $clog2(UNJAB_CYCLES + 1);
  localparam logic [TW-1:0] TRIP_LIMIT  = TW'(TRIP_CYCLES);
  localparam logic [QW-1:0] QUIET_LIMIT = QW'(UNJAB_CYCLES - 1);

  logic [TW-1:0] tripCnt;
  logic [QW-1:0] quietCnt;

  // length of the current high run of transmit enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 tripCnt <= '0;
    else if (strobe.tripClr)   tripCnt <= '0;
    else if (strobe.tripInc)   tripCnt <= tripCnt + 1'b1;
  end

  // length of the current low run while latched
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 quietCnt <= '0;
    else if (strobe.quietClr)  quietCnt <= '0;
    else if (strobe.quietInc)  quietCnt <= quietCnt + 1'b1;
  end

  assign tripHit   = (tripCnt == TRIP_LIMIT);
  assign quietHit  = (quietCnt == QUIET_LIMIT);
  assign tripZero  = (tripCnt == '0);
  assign quietZero = (quietCnt == '0);

  // R2: the trip count never runs past its limit
  assert_trip_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    tripCnt <= TRIP_LIMIT);

  // R7: the quiet count never runs past its limit
  assert_quiet_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    quietCnt <= QUIET_LIMIT);

endmodule

// File: rtl/jab_control.sv
module jab_control
  import jabwd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEn,
  input  logic       fullDuplex,
  input  logic       tripHit,
  input  logic       quietHit,
  output jabStrobe_t strobe,
  output logic       jabberActive,
  output logic       txDisable,
  output logic       crsKill,
  output logic       colReq,
  output logic       linkFailReq
);
  jabState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_ARMED: begin
        strobe.quietClr = 1'b1;
        if (!txEn) begin
          strobe.tripClr = 1'b1;
        end else if (tripHit) begin
          strobe.tripClr = 1'b1;
          stateNext      = ST_JABBED;
        end else begin
          strobe.tripInc = 1'b1;
        end
      end
      ST_JABBED: begin
        strobe.tripClr = 1'b1;
        if (txEn) begin
          strobe.quietClr = 1'b1;
        end else if (quietHit) begin
          strobe.quietClr = 1'b1;
          stateNext       = ST_ARMED;
        end else begin
          strobe.quietInc = 1'b1;
        end
      end
      default: stateNext = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ARMED;
    else       state <= stateNext;
  end

  assign jabberActive = (state == ST_JABBED);
  assign txDisable    = jabberActive;
  assign crsKill      = jabberActive;
  assign linkFailReq  = jabberActive & txEn;
  assign colReq       = jabberActive & txEn & ~fullDuplex;

  // R2: a run that reaches the limit while armed latches jabber
  assert_trip_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!jabberActive && txEn && tripHit) |=> jabberActive);

  // R7: jabber never releases on a cycle that sampled transmit enable high
  assert_release_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(jabberActive) |-> !$past(txEn));

endmodule

// File: rtl/jabber_watchdog.sv
module jabber_watchdog
  import jabwd_pkg::*;
#(
  parameter int unsigned TRIP_CYCLES  = 5_000_000,
  parameter int unsigned UNJAB_CYCLES = 125_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic txEn,
  input  logic fullDuplex,
  output logic jabberActive,
  output logic txDisable,
  output logic crsKill,
  output logic colReq,
  output logic linkFailReq
);
  jabStrobe_t strobe;
  logic tripHit, quietHit, tripZero, quietZero;

  jab_control u_control (
    .clk(clk), .rstN(rstN), .txEn(txEn), .fullDuplex(fullDuplex),
    .tripHit(tripHit), .quietHit(quietHit), .strobe(strobe),
    .jabberActive(jabberActive), .txDisable(txDisable), .crsKill(crsKill),
    .colReq(colReq), .linkFailReq(linkFailReq)
  );

  jab_counters #(.TRIP_CYCLES(TRIP_CYCLES), .UNJAB_CYCLES(UNJAB_CYCLES)) u_counters (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .tripHit(tripHit), .quietHit(quietHit),
    .tripZero(tripZero), .quietZero(quietZero)
  );

  // R6: a low sample leaves the trip count at zero
  assert_trip_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> tripZero);

  // R8: an attempt while latched restarts the quiet count
  assert_quiet_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    (jabberActive && txEn) |=> quietZero);

  // R5: no collision request in full duplex
  assert_no_col_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    fullDuplex |-> !colReq);

  // R4: a collision request always comes with a link-fail request
  assert_col_with_lf_R4: assert property (@(posedge clk) disable iff (!rstN)
    colReq |-> linkFailReq);

endmodule

// File: tb/jabber_watchdog_bench.sv
module jabber_watchdog_bench;
  localparam int unsigned TRIP  = 20;
  localparam int unsigned UNJAB = 30;

  typedef struct packed {
    logic       tx;
    logic       fd;
    logic [7:0] n;
    logic       expJab;
    logic       expCol;
    logic       expLf;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd5,  1'b0, 1'b0, 1'b0},  // R9 idle
    '{1'b1, 1'b0, 8'd20, 1'b0, 1'b0, 1'b0},  // R2 exactly TRIP high samples
    '{1'b0, 1'b0, 8'd1,  1'b0, 1'b0, 1'b0},  // R6 one low sample
    '{1'b1, 1'b0, 8'd20, 1'b0, 1'b0, 1'b0},  // R6 new run timed from its start
    '{1'b1, 1'b0, 8'd1,  1'b1, 1'b1, 1'b1},  // R2 trip, R5 col in half duplex
    '{1'b0, 1'b0, 8'd29, 1'b1, 1'b0, 1'b0},  // R4 no attempt -> no link fail
    '{1'b1, 1'b1, 8'd1,  1'b1, 1'b0, 1'b1},  // R5 full duplex, R8 restart
    '{1'b0, 1'b0, 8'd29, 1'b1, 1'b0, 1'b0},  // R8 still latched
    '{1'b0, 1'b0, 8'd1,  1'b0, 1'b0, 1'b0},  // R7 clears on 30th quiet sample
    '{1'b1, 1'b1, 8'd5,  1'b0, 1'b0, 1'b0},  // R9 attempts while not latched
    '{1'b1, 1'b1, 8'd16, 1'b1, 1'b0, 1'b1},  // R2 trip in full duplex
    '{1'b0, 1'b1, 8'd30, 1'b0, 1'b0, 1'b0}   // R7 clear
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEn = 1'b0;
  logic fullDuplex = 1'b0;
  logic jabberActive, txDisable, crsKill, colReq, linkFailReq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  jabber_watchdog #(.TRIP_CYCLES(TRIP), .UNJAB_CYCLES(UNJAB)) u_jabber_watchdog (
    .clk(clk), .rstN(rstN), .txEn(txEn), .fullDuplex(fullDuplex),
    .jabberActive(jabberActive), .txDisable(txDisable), .crsKill(crsKill),
    .colReq(colReq), .linkFailReq(linkFailReq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll(input logic jab, input logic col, input logic lf);
    check("R2/R7 jabberActive", jabberActive, jab);
    check("R3 txDisable", txDisable, jab);
    check("R3 crsKill", crsKill, jab);
    check("R5 colReq", colReq, col);
    check("R4 linkFailReq", linkFailReq, lf);
  endtask

  task automatic drive(input logic tx, input logic fd, input int n);
    @(negedge clk);
    txEn = tx;
    fullDuplex = fd;
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkAll(1'b0, 1'b0, 1'b0);  // R1 during reset
    @(negedge clk);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].tx, VECS[v].fd, int'(VECS[v].n));
      checkAll(VECS[v].expJab, VECS[v].expCol, VECS[v].expLf);
    end

    // R1: reset while latched
    drive(1'b1, 1'b0, 21);
    checkAll(1'b1, 1'b1, 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkAll(1'b0, 1'b0, 1'b0);  // R1 asynchronous clear
    @(negedge clk);
    rstN = 1'b1;
    // R1/R6: count starts from zero after reset with txEn already high
    for (int i = 0; i < int'(TRIP); i++) @(posedge clk);
    #1;
    checkAll(1'b0, 1'b0, 1'b0);
    @(posedge clk);
    #1;
    checkAll(1'b1, 1'b1, 1'b1);  // R2 trip after reset
    // R7: one short of the quiet limit, then the limit
    drive(1'b0, 1'b0, UNJAB - 1);
    checkAll(1'b1, 1'b0, 1'b0);
    @(posedge clk);
    #1;
    checkAll(1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule